// File: doc/BRIEF.md
# Dual-Converter Mode Sequencer

This block sequences two abstract sigma-delta conversion channels, a primary and an auxiliary, from one 8-bit control byte. The byte holds one enable bit per channel and a shared 3-bit operating mode. Whenever the byte is written, or a channel's configuration changes, the sequencer issues one-cycle restart pulses to the channels. It then runs them in power-down, idle, one-shot, free-running or calibration operation, and it strobes the result and calibration registers as each channel produces an output.

Each channel is modelled as a period counter that emits a result strobe every P clocks. P is the programmed rate, with a floor of two clocks. During any calibration P is fixed at the slowest setting. An auxiliary channel restarted on its own while the primary is converting does not free-run. It waits until the third primary output, and from then on it emits only in cycles where the primary emits. One-shot and calibration operations clear the mode field back to power-down once every enabled channel has produced its result.

Top module: `dualConvSeq`

## Requirements
- R1: The control byte reads back with bit 5 = primary enable, bit 4 = auxiliary enable and bits 2:0 = mode. Bits 7, 6 and 3 always read 0. The byte is 0x00 after reset, and every status output is low after reset.
- R2: Every control-byte write pulses both `priRst` and `auxRst` for the cycle after the write edge. This holds even when the written value equals the stored one, and the first result then comes P+1 clock edges after the write edge.
- R3: A primary configuration strobe pulses both restarts when the primary is enabled. When the primary is disabled it pulses neither.
- R4: An auxiliary configuration strobe pulses `auxRst` only. The primary result cadence continues at period P without a gap.
- R5: In mode 011 (continuous), an enabled channel strobes its valid and data-write outputs every P clocks, where P = max(`rateSel`, 2). The channel's ready flag is set on the following edge.
- R6: After an auxiliary-only restart while the primary is running, auxiliary results appear only in primary result cycles, starting at the third primary result after the restart. After a joint restart the first auxiliary result coincides with the first primary result. When the primary is not running, the auxiliary uses its own P-clock counter.
- R7: In mode 001 (idle), the hold output of each enabled channel is high and no result strobes occur.
- R8: In mode 010 (single), each enabled channel produces exactly one result. The mode field reads 000 from the edge after the last result.
- R9: Writing a mode 1xx (calibration) clears both ready flags at the write edge. Results then come every `CAL_PERIOD` clocks regardless of `rateSel`, each strobing the channel's calibration-write output, and the mode field returns to 000 on the edge after the last result.
- R10: An auxiliary calibration result while `auxTempSel` is high sets `auxRdy` and `auxErr` and does not strobe `auxCalWr`. `auxErr` is cleared by the next calibration write.
- R11: A disabled channel produces no result strobes and no hold, and its ready flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte write value |
| priCfgWr | input | 1 | Primary channel configuration written |
| auxCfgWr | input | 1 | Auxiliary channel configuration written |
| auxTempSel | input | 1 | Auxiliary input is the temperature sensor |
| rateSel | input | RATE_W | Output period in clocks for conversions |
| ctrlRdData | output | 8 | Control byte read-back |
| priRst | output | 1 | Primary channel restart pulse |
| auxRst | output | 1 | Auxiliary channel restart pulse |
| priHold | output | 1 | Primary filter and modulator held (idle) |
| auxHold | output | 1 | Auxiliary filter and modulator held (idle) |
| priValid | output | 1 | Primary result strobe |
| auxValid | output | 1 | Auxiliary result strobe |
| priDataWr | output | 1 | Primary data register update |
| auxDataWr | output | 1 | Auxiliary data register update |
| priCalWr | output | 1 | Primary calibration register update |
| auxCalWr | output | 1 | Auxiliary calibration register update |
| priRdy | output | 1 | Primary ready flag |
| auxRdy | output | 1 | Auxiliary ready flag |
| auxErr | output | 1 | Auxiliary calibration error flag |

## Verification
Random control bytes check the read-back mask and show that every write restarts both channels. Random rates in continuous mode measure both the first-result latency and the steady period, which separates an off-by-one in the counter from a missed restart or a missing rate floor. Directed sequences cover the rest:
- a rewrite with the same value in the middle of a count;
- an auxiliary-only restart during primary conversion, which separates lockstep alignment from free-running and checks that the primary is not disturbed;
- primary configuration writes with the primary enabled and disabled;
- idle and fully disabled operation;
- single conversions and calibrations with and without the temperature input, which show the auto-return timing, the ready clearing and the error path.

// File: rtl/dcsPkg.sv
package dcsPkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_IDLE   = 3'd1,
    MODE_SINGLE = 3'd2,
    MODE_CONT   = 3'd3,
    MODE_CAL_IZ = 3'd4,
    MODE_CAL_IF = 3'd5,
    MODE_CAL_SZ = 3'd6,
    MODE_CAL_SF = 3'd7
  } modeE;

  // Control-byte field positions (read-back layout is part of the behaviour)
  localparam int PRI_EN_BIT = 5;
  localparam int AUX_EN_BIT = 4;
  localparam int CAL_BIT    = 2;

  // Strobes from the control unit to the channel datapath
  typedef struct packed {
    logic rstBoth;   // restart both channels this cycle
    logic rstAux;    // restart auxiliary only
    logic priRun;    // primary counts
    logic auxRun;    // auxiliary counts
    logic lockstep;  // auxiliary follows primary outputs
    logic calMode;   // use calibration period
  } ctrlStrbT;

endpackage

// File: rtl/dcsTimer.sv
module dcsTimer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    fire = run && !clear && (cnt == period - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dcsData.sv
module dcsData
  import dcsPkg::*;
#(
  parameter int RATE_W     = 8,
  parameter int CAL_PERIOD = 64,
  parameter int MIN_RATE   = 2,
  parameter int AUX_SYNC   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrbT          strb,
  input  logic [RATE_W-1:0] rateSel,
  output logic              priTick,
  output logic              auxTick
);

  localparam int CAL_W  = $clog2(CAL_PERIOD + 1);
  localparam int CNT_W  = (RATE_W > CAL_W) ? RATE_W : CAL_W;
  localparam int SYNC_W = (AUX_SYNC > 1) ? $clog2(AUX_SYNC) : 1;
  localparam int N_CH   = 2;
  localparam logic [RATE_W-1:0] MIN_R    = RATE_W'(MIN_RATE);
  localparam logic [SYNC_W-1:0] SYNC_END = SYNC_W'(AUX_SYNC - 1);

  logic [CNT_W-1:0]  period;
  logic [N_CH-1:0]   chClear;
  logic [N_CH-1:0]   chRun;
  logic [N_CH-1:0]   chFire;
  logic [SYNC_W-1:0] syncCnt;
  logic              syncDone;
  logic              auxClr;
  logic              auxFire;
  logic              priTickQ;
  logic              auxTickQ;

  always_comb begin
    if (strb.calMode)        period = CNT_W'(CAL_PERIOD);
    else if (rateSel < MIN_R) period = CNT_W'(MIN_R);
    else                     period = CNT_W'(rateSel);
  end

  assign auxClr     = strb.rstBoth || strb.rstAux;
  assign chClear[0] = strb.rstBoth;
  assign chClear[1] = auxClr;
  assign chRun[0]   = strb.priRun;
  assign chRun[1]   = strb.auxRun && !strb.lockstep;

  for (genvar ch = 0; ch < N_CH; ch++) begin : gCh
    dcsTimer #(.CNT_W(CNT_W)) uTimer (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (chClear[ch]),
      .run    (chRun[ch]),
      .period (period),
      .fire   (chFire[ch])
    );
  end

  assign syncDone = (syncCnt == SYNC_END);

  always_comb begin
    if (strb.lockstep)
      auxFire = strb.auxRun && chFire[0] && syncDone && !auxClr;
    else
      auxFire = chFire[1];
  end

  // Auxiliary alignment: counts primary outputs after an auxiliary-only restart
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCnt <= SYNC_END;
    end else if (strb.rstBoth) begin
      syncCnt <= SYNC_END;
    end else if (strb.rstAux) begin
      syncCnt <= '0;
    end else if (strb.lockstep && strb.auxRun && chFire[0] && !syncDone) begin
      syncCnt <= syncCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priTickQ <= 1'b0;
      auxTickQ <= 1'b0;
    end else begin
      priTickQ <= chFire[0];
      auxTickQ <= auxFire;
    end
  end

  // A result landing in a restart cycle belongs to the old operation: drop it
  assign priTick = priTickQ && !strb.rstBoth;
  assign auxTick = auxTickQ && !auxClr;

  assert_aux_in_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lockstep && auxFire) |=> priTickQ);

  assert_quiet_when_stopped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.priRun) |=> !priTickQ);

endmodule

// File: rtl/dcsCtrl.sv
module dcsCtrl
  import dcsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlWrData,
  input  logic       priCfgWr,
  input  logic       auxCfgWr,
  input  logic       auxTempSel,
  input  logic       priTick,
  input  logic       auxTick,
  output ctrlStrbT   strb,
  output logic [7:0] ctrlRdData,
  output logic       priHold,
  output logic       auxHold,
  output logic       priDataWr,
  output logic       auxDataWr,
  output logic       priCalWr,
  output logic       auxCalWr,
  output logic       priRdy,
  output logic       auxRdy,
  output logic       auxErr
);

  logic priEn;
  logic auxEn;
  modeE mode;
  logic rstBothQ;
  logic rstAuxQ;
  logic priDone;
  logic auxDone;
  logic calMode;
  logic convMode;
  logic oneShot;
  logic runMode;
  logic wrCal;
  logic bothEvt;
  logic auxEvt;
  logic finish;
  logic unusedRsvd;

  assign unusedRsvd = ^{ctrlWrData[7:6], ctrlWrData[3]};

  assign calMode  = mode[CAL_BIT];
  assign convMode = (mode == MODE_SINGLE) || (mode == MODE_CONT);
  assign oneShot  = (mode == MODE_SINGLE) || calMode;
  assign runMode  = convMode || calMode;
  assign wrCal    = ctrlWr && ctrlWrData[CAL_BIT];
  assign bothEvt  = ctrlWr || (priCfgWr && priEn);
  assign auxEvt   = auxCfgWr && !bothEvt;

  assign finish = oneShot && (priEn || auxEn)
               && (!priEn || priDone || priTick)
               && (!auxEn || auxDone || auxTick);

  // Control byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priEn <= 1'b0;
      auxEn <= 1'b0;
      mode  <= MODE_OFF;
    end else if (ctrlWr) begin
      priEn <= ctrlWrData[PRI_EN_BIT];
      auxEn <= ctrlWrData[AUX_EN_BIT];
      mode  <= modeE'(ctrlWrData[2:0]);
    end else if (finish) begin
      mode  <= MODE_OFF;
    end
  end

  assign ctrlRdData = {2'b00, priEn, auxEn, 1'b0, mode};

  // Restart strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstBothQ <= 1'b0;
      rstAuxQ  <= 1'b0;
    end else begin
      rstBothQ <= bothEvt;
      rstAuxQ  <= auxEvt;
    end
  end

  // One-shot completion tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priDone <= 1'b0;
      auxDone <= 1'b0;
    end else begin
      if (bothEvt)                  priDone <= 1'b0;
      else if (priTick && oneShot)  priDone <= 1'b1;
      if (bothEvt || auxCfgWr)      auxDone <= 1'b0;
      else if (auxTick && oneShot)  auxDone <= 1'b1;
    end
  end

  // Status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priRdy <= 1'b0;
      auxRdy <= 1'b0;
      auxErr <= 1'b0;
    end else if (wrCal) begin
      priRdy <= 1'b0;
      auxRdy <= 1'b0;
      auxErr <= 1'b0;
    end else begin
      if (priTick) priRdy <= 1'b1;
      if (auxTick) auxRdy <= 1'b1;
      if (auxTick && calMode && auxTempSel) auxErr <= 1'b1;
    end
  end

  always_comb begin
    strb.rstBoth  = rstBothQ;
    strb.rstAux   = rstAuxQ;
    strb.priRun   = priEn && runMode && !(oneShot && priDone);
    strb.auxRun   = auxEn && runMode && !(oneShot && auxDone);
    strb.lockstep = strb.priRun;
    strb.calMode  = calMode;
  end

  assign priHold   = priEn && (mode == MODE_IDLE);
  assign auxHold   = auxEn && (mode == MODE_IDLE);
  assign priDataWr = priTick && convMode;
  assign auxDataWr = auxTick && convMode;
  assign priCalWr  = priTick && calMode;
  assign auxCalWr  = auxTick && calMode && !auxTempSel;

  assert_write_restarts_both_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (rstBothQ && rstAuxQ == 1'b0 && strb.rstBoth));

  assert_aux_cfg_local_R4: assert property (@(posedge clk) disable iff (!rstN)
    (auxCfgWr && !ctrlWr && !(priCfgWr && priEn)) |=> (strb.rstAux && !strb.rstBoth));

  assert_cal_clears_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCal |=> (!priRdy && !auxRdy));

  assert_temp_cal_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    (auxTick && calMode && auxTempSel && !ctrlWr) |=> (auxErr && auxRdy));

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    priHold |-> !priTick);

endmodule

// File: rtl/dualConvSeq.sv
module dualConvSeq
  import dcsPkg::*;
#(
  parameter int RATE_W     = 8,
  parameter int CAL_PERIOD = 64,
  parameter int MIN_RATE   = 2,
  parameter int AUX_SYNC   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [7:0]        ctrlWrData,
  input  logic              priCfgWr,
  input  logic              auxCfgWr,
  input  logic              auxTempSel,
  input  logic [RATE_W-1:0] rateSel,
  output logic [7:0]        ctrlRdData,
  output logic              priRst,
  output logic              auxRst,
  output logic              priHold,
  output logic              auxHold,
  output logic              priValid,
  output logic              auxValid,
  output logic              priDataWr,
  output logic              auxDataWr,
  output logic              priCalWr,
  output logic              auxCalWr,
  output logic              priRdy,
  output logic              auxRdy,
  output logic              auxErr
);

  ctrlStrbT strb;
  logic     priTick;
  logic     auxTick;

  dcsCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (ctrlWrData),
    .priCfgWr   (priCfgWr),
    .auxCfgWr   (auxCfgWr),
    .auxTempSel (auxTempSel),
    .priTick    (priTick),
    .auxTick    (auxTick),
    .strb       (strb),
    .ctrlRdData (ctrlRdData),
    .priHold    (priHold),
    .auxHold    (auxHold),
    .priDataWr  (priDataWr),
    .auxDataWr  (auxDataWr),
    .priCalWr   (priCalWr),
    .auxCalWr   (auxCalWr),
    .priRdy     (priRdy),
    .auxRdy     (auxRdy),
    .auxErr     (auxErr)
  );

  dcsData #(
    .RATE_W     (RATE_W),
    .CAL_PERIOD (CAL_PERIOD),
    .MIN_RATE   (MIN_RATE),
    .AUX_SYNC   (AUX_SYNC)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rateSel (rateSel),
    .priTick (priTick),
    .auxTick (auxTick)
  );

  assign priRst   = strb.rstBoth;
  assign auxRst   = strb.rstBoth || strb.rstAux;
  assign priValid = priTick;
  assign auxValid = auxTick;

endmodule

// File: tb/sim_dualConvSeq.sv
module sim_dualConvSeq;

  localparam int CAL_P = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic       priCfgWr = 1'b0;
  logic       auxCfgWr = 1'b0;
  logic       auxTempSel = 1'b0;
  logic [7:0] rateSel = 8'd4;
  logic [7:0] ctrlRdData;
  logic priRst, auxRst, priHold, auxHold, priValid, auxValid;
  logic priDataWr, auxDataWr, priCalWr, auxCalWr, priRdy, auxRdy, auxErr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  int fPri, sPri, fAux, nPri, nAux, modeZeroAt, priCalAt, auxCalCnt;
  bit priDwFirst;

  dualConvSeq u0 (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .priCfgWr(priCfgWr), .auxCfgWr(auxCfgWr), .auxTempSel(auxTempSel),
    .rateSel(rateSel), .ctrlRdData(ctrlRdData), .priRst(priRst), .auxRst(auxRst),
    .priHold(priHold), .auxHold(auxHold), .priValid(priValid), .auxValid(auxValid),
    .priDataWr(priDataWr), .auxDataWr(auxDataWr), .priCalWr(priCalWr),
    .auxCalWr(auxCalWr), .priRdy(priRdy), .auxRdy(auxRdy), .auxErr(auxErr)
  );

  always #4 clk = ~clk;

  function automatic int expRead(input logic [7:0] b);
    return int'(b & 8'h37);
  endfunction

  function automatic int expPeriod(input int r);
    return (r < 2) ? 2 : r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWrData = d;
    ctrlWr = 1'b1;
    cyc();
    ctrlWr = 1'b0;
  endtask

  task automatic observe(input int limit);
    fPri = -1; sPri = -1; fAux = -1; nPri = 0; nAux = 0;
    modeZeroAt = -1; priCalAt = -1; auxCalCnt = 0; priDwFirst = 1'b0;
    for (int n = 1; n <= limit; n++) begin
      cyc();
      if (priValid) begin
        nPri++;
        if (fPri < 0) begin fPri = n; priDwFirst = priDataWr; end
        else if (sPri < 0) sPri = n;
      end
      if (auxValid) begin nAux++; if (fAux < 0) fAux = n; end
      if (priCalWr && priCalAt < 0) priCalAt = n;
      if (auxCalWr) auxCalCnt++;
      if (modeZeroAt < 0 && ctrlRdData[2:0] == 3'b000) modeZeroAt = n;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    check(ctrlRdData == 8'h00, "R1 reset byte", int'(ctrlRdData), 0);
    check({priRdy, auxRdy, auxErr, priValid, auxValid, priRst, auxRst} == 7'd0,
          "R1 reset status", int'({priRdy, auxRdy, auxErr}), 0);

    // R1 / R2 random bytes: read-back mask and joint restart on every write
    for (int i = 0; i < 24; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      wrCtrl(b);
      check(int'(ctrlRdData) == expRead(b), "R1 readback", int'(ctrlRdData), expRead(b));
      check(priRst && auxRst, "R2 write restart", int'({priRst, auxRst}), 3);
    end
    wrCtrl(8'h00);

    // R5 random rates, primary continuous
    for (int i = 0; i < 8; i++) begin
      int p;
      rateSel = 8'($urandom_range(0, 12));
      p = expPeriod(int'(rateSel));
      wrCtrl(8'h23);
      observe(2 * p + 3);
      check(fPri == p + 1, "R5 first result", fPri, p + 1);
      check(sPri == 2 * p + 1, "R5 period", sPri, 2 * p + 1);
      check(priDwFirst, "R5 data write", int'(priDwFirst), 1);
      check(priRdy, "R5 ready", int'(priRdy), 1);
      check(nAux == 0, "R11 aux disabled quiet", nAux, 0);
    end

    // R2 same-value rewrite mid-count restarts timing
    rateSel = 8'd6;
    wrCtrl(8'h23);
    repeat (3) cyc();
    wrCtrl(8'h23);
    check(priRst && auxRst, "R2 rewrite restart", int'({priRst, auxRst}), 3);
    observe(8);
    check(fPri == 7, "R2 rewrite timing", fPri, 7);

    // R6 auxiliary alone runs its own counter
    rateSel = 8'd3;
    wrCtrl(8'h13);
    observe(8);
    check(fAux == 4, "R6 aux own counter", fAux, 4);
    check(nPri == 0, "R11 primary disabled quiet", nPri, 0);

    // R3 primary configuration write while disabled / enabled
    priCfgWr = 1'b1; cyc(); priCfgWr = 1'b0;
    check(!priRst && !auxRst, "R3 disabled cfg", int'({priRst, auxRst}), 0);
    rateSel = 8'd5;
    wrCtrl(8'h33);
    observe(6);
    check(fPri == 6 && fAux == 6, "R6 joint aligned", fAux, 6);
    // now in a primary result cycle; restart auxiliary only
    auxCfgWr = 1'b1; cyc(); auxCfgWr = 1'b0;
    check(auxRst && !priRst, "R4 aux-only restart", int'({priRst, auxRst}), 1);
    begin
      int lastPri = -1, priIdx = 0, auxIdx = -1, orphan = 0, badGap = 0;
      for (int n = 1; n <= 40; n++) begin
        cyc();
        if (priValid) begin
          priIdx++;
          if (n - lastPri != 5) badGap++;
          lastPri = n;
        end
        if (auxValid) begin
          if (!priValid) orphan++;
          if (auxIdx < 0) auxIdx = priIdx;
        end
      end
      check(badGap == 0, "R4 primary cadence", badGap, 0);
      check(orphan == 0, "R6 aux in step", orphan, 0);
      check(auxIdx == 3, "R6 third primary", auxIdx, 3);
    end
    priCfgWr = 1'b1; cyc(); priCfgWr = 1'b0;
    check(priRst && auxRst, "R3 enabled cfg", int'({priRst, auxRst}), 3);

    // R7 idle
    wrCtrl(8'h21);
    check(priHold && !auxHold, "R7 hold", int'({priHold, auxHold}), 2);
    observe(30);
    check(nPri == 0 && nAux == 0, "R7 idle quiet", nPri + nAux, 0);

    // R11 both disabled
    begin
      logic r0, r1;
      r0 = priRdy; r1 = auxRdy;
      wrCtrl(8'h03);
      observe(30);
      check(nPri == 0 && nAux == 0 && !priHold && !auxHold, "R11 no activity", nPri + nAux, 0);
      check(priRdy == r0 && auxRdy == r1, "R11 ready kept", int'({priRdy, auxRdy}), int'({r0, r1}));
    end

    // R8 single conversion
    rateSel = 8'd4;
    wrCtrl(8'h32);
    observe(30);
    check(fPri == 5 && fAux == 5, "R8 single result", fPri, 5);
    check(nPri == 1 && nAux == 1, "R8 one result", nPri + nAux, 2);
    check(modeZeroAt == 6, "R8 mode return", modeZeroAt, 6);
    check(ctrlRdData == 8'h30, "R8 byte after", int'(ctrlRdData), 8'h30);

    // R9 / R10 calibration with temperature input
    auxTempSel = 1'b1;
    wrCtrl(8'h34);
    check(!priRdy && !auxRdy && !auxErr, "R9 ready cleared", int'({priRdy, auxRdy, auxErr}), 0);
    observe(CAL_P + 10);
    check(fPri == CAL_P + 1 && fAux == CAL_P + 1, "R9 cal period", fPri, CAL_P + 1);
    check(priCalAt == CAL_P + 1, "R9 cal write", priCalAt, CAL_P + 1);
    check(auxCalCnt == 0, "R10 no aux cal write", auxCalCnt, 0);
    check(modeZeroAt == CAL_P + 2, "R9 mode return", modeZeroAt, CAL_P + 2);
    check(priRdy && auxRdy && auxErr, "R10 flags", int'({priRdy, auxRdy, auxErr}), 7);

    auxTempSel = 1'b0;
    rateSel = 8'd9;
    wrCtrl(8'h35);
    check(!auxErr, "R10 error cleared", int'(auxErr), 0);
    observe(CAL_P + 4);
    check(auxCalCnt == 1 && !auxErr, "R10 normal aux cal", auxCalCnt, 1);
    check(fAux == CAL_P + 1, "R9 rate ignored", fAux, CAL_P + 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule